// File: doc/BRIEF.md
# Refresh interval compare timer

This block produces a steady cadence of events from the system clock. A free-running prescaler divides the clock by one of seven ratios, and an 8-bit up-counter advances once per prescaler tick. The counter is compared with a host-programmed constant. When they are equal on a tick, the counter returns to zero, a sticky match flag is set, and a one-cycle refresh request pulse is sent out. The flag can also raise an interrupt when the host has enabled it.

Two mode inputs mark the timer as the refresh time base for pseudo-static or dynamic memory. While either input is high, the interrupt enable is held low and the clock-select field cannot be changed. A memory controller can therefore rely on the request cadence without software disturbing it.

The host reaches three registers through a small synchronous bus with registered read data. These are a control/status register, the counter, and the compare constant.

Top module: `rfsh_cmp_timer`

## Requirements
- R1: Register addresses are 0 = control/status, 1 = counter and 2 = compare constant. A read returns its data on `host_rdata` one clock after `host_rd` is sampled. The control/status layout is bit 7 match flag, bit 6 interrupt enable, bits 5:3 clock select, and bits 2:0 reserved. The reserved bits always read as 1 and ignore writes. After reset the control/status register reads 0x07, the counter reads 0x00 and the constant reads 0xFF.
- R2: Clock-select code 0 stops the counter. Codes 1 to 7 advance it once every 2, 8, 32, 128, 512, 2048 and 4096 clocks respectively, taken from a free-running prescaler.
- R3: On a tick where the counter equals the constant, the counter goes to 0x00 and the flag is set. Consecutive matches are therefore (constant+1) × divide clocks apart.
- R4: `rfsh_req` is high for exactly one clock after each match, whatever the interrupt enable is. It is high in the first cycle in which the flag reads as set.
- R5: `irq` is high exactly while the flag is 1 and the effective interrupt enable is 1.
- R6: While `mode_psram` or `mode_dram` is high, the interrupt enable reads as 0, `irq` stays low, and the stored enable is cleared.
- R7: While `mode_psram` or `mode_dram` is high, host writes to the clock-select field are ignored. Counting continues with the previous selection.
- R8: The flag clears only when a control/status write with bit 7 = 0 follows a control/status read that returned the flag as 1. Writing bit 7 = 1 has no effect. A match in the same cycle as the clearing write leaves the flag set.
- R9: A host write to the counter wins over a tick in the same cycle. The written value is stored exactly, and no match is evaluated in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register select |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| mode_psram | input | 1 | Pseudo-static RAM refresh mode enable |
| mode_dram | input | 1 | DRAM refresh mode enable |
| irq | output | 1 | Compare-match interrupt |
| rfsh_req | output | 1 | One-cycle refresh request per match |

## Verification
The match cadence is measured as the clock count between consecutive refresh pulses. It is measured for every clock-select code with a fixed constant, which separates the seven divide ratios. It is also measured for several constants, including 0 and 255, at the fastest ratio, which separates off-by-one errors in the compare from errors in the prescaler. The flag-clear handshake is tried in three ways: without a prior read, with bit 7 written as 1, and with the clearing write placed on each clock phase of a match every second cycle. Comparing these cases shows whether the match or the clear takes priority. Counter writes are placed on both tick phases, and the mode inputs are raised with a counting selection, which shows that the lock freezes the configuration without stopping the requests.

// File: rtl/rct_pkg.sv
package rct_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int CKS_W   = 3;
  localparam int NUM_DIV = (1 << CKS_W) - 1;
  localparam int PRE_W   = 12;

  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int CKS_LSB  = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CSR = 2'd0,
    REG_CNT = 2'd1,
    REG_CMP = 2'd2
  } reg_sel_e;

  // log2 of the divide ratio for select code 1..7
  function automatic int div_shift(input int code);
    if (code <= 0)           return 0;
    else if (code >= NUM_DIV) return PRE_W;
    else                      return 2 * code - 1;
  endfunction
endpackage

// File: rtl/rct_prescaler.sv
module rct_prescaler
  import rct_pkg::*;
#(
  parameter int SEL_W = CKS_W,
  parameter int DIVW  = PRE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NOPT = (1 << SEL_W) - 1;

  logic [DIVW-1:0] pre_q;
  logic [NOPT:0]   opt_tick;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  assign opt_tick[0] = 1'b0;

  generate
    for (genvar gi = 1; gi <= NOPT; gi++) begin : g_opt
      localparam int SH = div_shift(gi);
      assign opt_tick[gi] = &pre_q[SH-1:0];
    end
  endgenerate

  assign tick = opt_tick[sel];
endmodule

// File: rtl/rct_counter.sv
module rct_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] limit,
  output logic [W-1:0] value,
  output logic         match
);
  logic at_limit;

  assign at_limit = (value == limit);
  assign match    = tick & ~load & at_limit;

  always_ff @(posedge clk) begin
    if (rst)            value <= '0;
    else if (load)      value <= load_val;
    else if (tick) begin
      if (at_limit)     value <= '0;
      else              value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/rct_regs.sv
module rct_regs
  import rct_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int SW = CKS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  input  logic          mode_psram,
  input  logic          mode_dram,
  input  logic [DW-1:0] cnt,
  input  logic          match,
  output logic [SW-1:0] cks,
  output logic [DW-1:0] cmp,
  output logic          cnt_wr,
  output logic          flag,
  output logic          ie_eff,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          rfsh_req
);
  logic          locked;
  logic          csr_wr, csr_rd, cmp_wr;
  logic          ie_q, armed_q;
  logic [DW-1:0] csr_val, rd_mux;

  assign locked = mode_psram | mode_dram;
  assign csr_wr = host_wr && (host_addr == REG_CSR);
  assign csr_rd = host_rd && (host_addr == REG_CSR);
  assign cmp_wr = host_wr && (host_addr == REG_CMP);
  assign cnt_wr = host_wr && (host_addr == REG_CNT);

  assign ie_eff = ie_q & ~locked;
  assign irq    = flag & ie_eff;

  always_comb begin
    csr_val                   = '1;
    csr_val[FLAG_BIT]         = flag;
    csr_val[IE_BIT]           = ie_eff;
    csr_val[CKS_LSB +: SW]    = cks;
  end

  always_comb begin
    case (host_addr)
      REG_CSR: rd_mux = csr_val;
      REG_CNT: rd_mux = cnt;
      REG_CMP: rd_mux = cmp;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      armed_q  <= 1'b0;
      ie_q     <= 1'b0;
      cks      <= '0;
      cmp      <= '1;
      rdata    <= '0;
      rfsh_req <= 1'b0;
    end else begin
      rfsh_req <= match;

      if (match)
        flag <= 1'b1;
      else if (csr_wr && armed_q && !host_wdata[FLAG_BIT])
        flag <= 1'b0;

      if (csr_wr)      armed_q <= 1'b0;
      else if (csr_rd) armed_q <= flag;

      if (locked)      ie_q <= 1'b0;
      else if (csr_wr) ie_q <= host_wdata[IE_BIT];

      if (csr_wr && !locked) cks <= host_wdata[CKS_LSB +: SW];

      if (cmp_wr) cmp <= host_wdata;

      if (host_rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/rfsh_cmp_timer.sv
module rfsh_cmp_timer
  import rct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              mode_psram,
  input  logic              mode_dram,
  output logic              irq,
  output logic              rfsh_req
);
  logic [CKS_W-1:0]  cks;
  logic [DATA_W-1:0] cmp_val;
  logic [DATA_W-1:0] cnt;
  logic              cnt_wr, tick, match, flag, ie_eff;

  rct_prescaler #(.SEL_W(CKS_W), .DIVW(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .sel  (cks),
    .tick (tick)
  );

  rct_counter #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (cnt_wr),
    .load_val (host_wdata),
    .limit    (cmp_val),
    .value    (cnt),
    .match    (match)
  );

  rct_regs #(.DW(DATA_W), .AW(ADDR_W), .SW(CKS_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .mode_psram (mode_psram),
    .mode_dram  (mode_dram),
    .cnt        (cnt),
    .match      (match),
    .cks        (cks),
    .cmp        (cmp_val),
    .cnt_wr     (cnt_wr),
    .flag       (flag),
    .ie_eff     (ie_eff),
    .rdata      (host_rdata),
    .irq        (irq),
    .rfsh_req   (rfsh_req)
  );
endmodule

// File: rtl/rct_checker.sv
module rct_checker
  import rct_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              mode_psram,
  input logic              mode_dram,
  input logic              irq,
  input logic              rfsh_req,
  input logic              flag,
  input logic [CKS_W-1:0]  cks,
  input logic [DATA_W-1:0] cnt,
  input logic              match,
  input logic              cnt_wr
);
  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (cks == '0 && !cnt_wr) |=> $stable(cnt));

  assert_match_clears_R3: assert property (@(posedge clk) disable iff (rst)
    match |=> (cnt == '0));

  assert_req_with_flag_R4: assert property (@(posedge clk) disable iff (rst)
    rfsh_req |-> flag);

  assert_req_single_R4: assert property (@(posedge clk) disable iff (rst)
    rfsh_req |=> !rfsh_req);

  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> flag);

  assert_mode_masks_irq_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_psram || mode_dram) |-> !irq);

  assert_cks_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_psram || mode_dram) |=> $stable(cks));
endmodule

bind rfsh_cmp_timer rct_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_psram (mode_psram),
  .mode_dram  (mode_dram),
  .irq        (irq),
  .rfsh_req   (rfsh_req),
  .flag       (flag),
  .cks        (cks),
  .cnt        (cnt),
  .match      (match),
  .cnt_wr     (cnt_wr)
);

// File: tb/rfsh_cmp_timer_bench.sv
module rfsh_cmp_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       mode_psram = 1'b0;
  logic       mode_dram = 1'b0;
  logic       irq, rfsh_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  rfsh_cmp_timer u_rfsh_cmp_timer (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mode_psram(mode_psram), .mode_dram(mode_dram), .irq(irq), .rfsh_req(rfsh_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_req(output bit seen);
    int guard = 0;
    while (!rfsh_req && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    seen = rfsh_req;
  endtask

  function automatic int ratio(input int code);
    if (code == 7) return 4096;
    return 1 << (2 * code - 1);
  endfunction

  task automatic measure(input string req, input int code, input int lim);
    bit seen;
    int n;
    wr(2'd0, 8'(code << 3));
    wr(2'd2, 8'(lim));
    wr(2'd1, 8'd0);
    wait_req(seen);
    @(negedge clk);
    n = 1;
    while (!rfsh_req && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(req, n, (lim + 1) * ratio(code));
  endtask

  initial begin
    repeat (20000000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bit seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values and layout
    chk("R1 irq reset", irq, 0);
    chk("R4 req reset", rfsh_req, 0);
    rd(2'd0, v); chk("R1 csr reset", v, 8'h07);
    rd(2'd1, v); chk("R1 cnt reset", v, 8'h00);
    rd(2'd2, v); chk("R1 cmp reset", v, 8'hFF);

    // R2 stopped counter holds a written value
    wr(2'd1, 8'h33);
    repeat (50) @(negedge clk);
    rd(2'd1, v); chk("R2 stopped", v, 8'h33);

    // R1 reserved bits ignore writes
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R1 reserved", v, 8'h07);

    // R2 every divide ratio
    for (int c = 1; c <= 7; c++) measure("R2 divide", c, 2);

    // R3 several constants at the fastest ratio
    measure("R3 limit 0", 1, 0);
    measure("R3 limit 1", 1, 1);
    measure("R3 limit 7", 1, 7);
    measure("R3 limit 200", 1, 200);
    measure("R3 limit 255", 1, 255);

    // R4 request pulse and flag visible together, irq disabled
    wr(2'd0, 8'h08); wr(2'd2, 8'd3); wr(2'd1, 8'd0);
    wait_req(seen);
    chk("R4 req seen", seen, 1);
    chk("R4 irq off", irq, 0);
    @(negedge clk);
    chk("R4 one cycle", rfsh_req, 0);

    // R8 clear handshake (counter stopped)
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R8 no clear without read", v, 8'h87);
    wr(2'd0, 8'h80);
    rd(2'd0, v); chk("R8 write one no effect", v, 8'h87);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R8 cleared", v, 8'h07);

    // R5 interrupt follows flag and enable
    wr(2'd0, 8'h08);
    wait_req(seen);
    wr(2'd0, 8'h40);
    chk("R5 irq on", irq, 1);
    wr(2'd0, 8'h00);
    chk("R5 irq off by enable", irq, 0);
    wr(2'd0, 8'h40);
    chk("R5 irq on again", irq, 1);

    // R6 mode masks enable
    mode_dram = 1'b1;
    @(negedge clk);
    chk("R6 irq masked", irq, 0);
    rd(2'd0, v); chk("R6 enable reads 0", v, 8'h87);
    // R7 select write ignored under mode (flag clears as armed)
    wr(2'd0, 8'h58);
    rd(2'd0, v); chk("R7 select locked", v, 8'h07);
    mode_dram = 1'b0;
    @(negedge clk);
    rd(2'd0, v); chk("R6 stored enable cleared", v, 8'h07);

    // R7 counting continues under psram mode
    wr(2'd0, 8'h48); wr(2'd2, 8'd2); wr(2'd1, 8'd0);
    mode_psram = 1'b1;
    @(negedge clk);
    wr(2'd0, 8'h38);
    @(negedge clk);
    wait_req(seen);
    @(negedge clk);
    wait_req(seen);
    chk("R7 requests continue", seen, 1);
    chk("R6 irq held low", irq, 0);
    rd(2'd0, v); chk("R7 select kept", v, 8'h8F);
    mode_psram = 1'b0;
    @(negedge clk);

    // R8 match vs clear: match every second clock
    wr(2'd0, 8'h08); wr(2'd2, 8'd0);
    wait_req(seen);
    rd(2'd0, v);
    wait_req(seen);
    wr(2'd0, 8'h08);
    rd(2'd0, v); chk("R8 clear off-match", v, 8'h0F);
    rd(2'd0, v);
    wait_req(seen);
    @(negedge clk);
    wr(2'd0, 8'h08);
    rd(2'd0, v); chk("R8 match wins", v, 8'h8F);

    // R9 counter write beats tick, both phases
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'h40);
    rd(2'd1, v); chk("R9 write phase a", v, 8'h40);
    @(negedge clk);
    wr(2'd1, 8'h50);
    rd(2'd1, v); chk("R9 write phase b", v, 8'h50);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule